// File: doc/BRIEF.md
# Octet-Synchronous PPP Transmit Framer

This block turns a stream of frame bytes into an octet-synchronous PPP line stream. Bytes arrive one per cycle on a valid/ready input that carries start-of-frame and end-of-frame markers. The block puts a 7E flag around each frame, computes a frame check sequence over the payload and appends it, and escapes every byte that the configuration marks as a control character. Bytes leave one per cycle on a registered valid/ready output.

An escaped byte goes out as the pair 7D, then the original value with bit 5 inverted (XOR 20). The set of escaped codes is the union of four sources. The flag and escape codes themselves are always included. A 32-bit map covers codes 00 to 1F. An enable covers DEL (7F). Four extension codes, each with its own enable, complete the set. FCS bytes pass through the same escape logic as payload bytes. When flag sharing is enabled, a frame that follows a completed frame reuses that frame's closing flag as its own opening flag.

The configuration inputs must be held steady while a frame is in flight.

Top module: `ppp_octet_tx`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, out_valid is low.
- R2: With flag sharing off, every frame on the output starts with one 7E byte and ends with one 7E byte, and no other unescaped 7E appears.
- R3: With flag sharing on, a frame that starts after an earlier frame has sent its closing flag has no opening flag, so back-to-back frames are separated by a single 7E.
- R4: With cfg_fcs32 low, the two FCS bytes are the ones' complement of a CRC over the payload. The CRC uses the reflected polynomial 8408 with a preset of FFFF and is sent low byte first. For the ASCII payload "123456789" the bytes are 6E, 90.
- R5: With cfg_fcs32 high, the four FCS bytes are the ones' complement of a CRC over the payload. The CRC uses the reflected polynomial EDB88320 with a preset of FFFFFFFF and is sent low byte first. For "123456789" the bytes are 26, 39, F4, CB.
- R6: An escaped byte b is sent as 7D followed by b XOR 20. The bytes 7E and 7D are always escaped, and a byte that matches no escape rule is sent unchanged.
- R7: A byte b below 20 is escaped exactly when bit b of cfg_ctrl_map is set.
- R8: The byte 7F is escaped exactly when cfg_esc_del is high.
- R9: Extension code k sits in cfg_ext_codes bits 8k+7 down to 8k, for k = 0 to 3. A byte equal to code k is escaped when cfg_ext_en bit k is high.
- R10: FCS bytes are escaped by the same rules as payload bytes. in_ready is low from the cycle after a frame's last byte is accepted until the FCS and closing flag have been produced.
- R11: While out_valid is high and out_ready is low, out_valid and out_data hold. in_ready is low while the 7D of an escape pair is on the output.
- R12: A byte offered with in_sof low while no frame is open is accepted and discarded. It produces no output and does not change the FCS of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fcs32 | input | 1 | 1 selects the 32-bit FCS, 0 the 16-bit FCS |
| cfg_share_flag | input | 1 | Allows one flag to close a frame and open the next |
| cfg_ctrl_map | input | 32 | Bit b set escapes code b (00 to 1F) |
| cfg_esc_del | input | 1 | Escapes 7F when high |
| cfg_ext_codes | input | 32 | Four extension codes, code k in bits 8k+7:8k |
| cfg_ext_en | input | 4 | Enable for each extension code |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output line byte |

## Verification
The bench sends every one of the 256 byte values through two escape configurations whose map bits, DEL enable and extension enables differ. A design that indexes the map off by one, or that ignores a disabled extension code, sends a byte unchanged where a 7D pair is expected, or the reverse. Two fixed payloads are compared against the published CRC check values, which catches a wrong preset, a missing complement or a wrong FCS byte order. The bench also counts how many frames had an FCS byte that needed escaping, to expose a design that escapes only payload bytes. Flag sharing is checked by counting flags across back-to-back frames, where a duplicated or dropped flag changes the count. Random output back-pressure, together with bytes offered outside a frame, shows whether the design loses the second byte of an escape pair under a stall, or lets stray bytes into the output or into the CRC.

// File: rtl/ppp_tx_pkg.sv
package ppp_tx_pkg;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
    localparam logic [7:0] ESC_BYTE  = 8'h7D;
    localparam logic [7:0] DEL_BYTE  = 8'h7F;
    localparam logic [7:0] ESC_XOR   = 8'h20;

    localparam logic [31:0] POLY32   = 32'hEDB8_8320;
    localparam logic [31:0] POLY16   = 32'h0000_8408;
    localparam logic [31:0] PRESET32 = 32'hFFFF_FFFF;
    localparam logic [31:0] PRESET16 = 32'h0000_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_FCS   = 2'd2,
        ST_CLOSE = 2'd3
    } tx_state_t;

    typedef struct packed {
        tx_state_t   state;
        logic [31:0] crc;
        logic [1:0]  fcs_idx;
        logic        after_close;
        logic        esc_pend;
        logic [7:0]  esc_byte;
        logic        out_valid;
        logic [7:0]  out_data;
    } tx_regs_t;

endpackage

// File: rtl/ppp_tx_escape.sv
module ppp_tx_escape
    import ppp_tx_pkg::*;
#(
    parameter int NUM_EXT = 4,
    localparam int EXT_W  = 8 * NUM_EXT
) (
    input  logic [7:0]         byte_in,
    input  logic [31:0]        ctrl_map,
    input  logic               esc_del,
    input  logic [EXT_W-1:0]   ext_codes,
    input  logic [NUM_EXT-1:0] ext_en,
    output logic               need_esc
);

    logic [NUM_EXT-1:0] ext_hit;
    logic               ctrl_hit;
    logic               fixed_hit;
    logic               del_hit;

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        assign ext_hit[k] = ext_en[k] && (ext_codes[8*k +: 8] == byte_in);
    end

    always_comb begin
        ctrl_hit  = (byte_in[7:5] == 3'b000) && ctrl_map[byte_in[4:0]];
        fixed_hit = (byte_in == FLAG_BYTE) || (byte_in == ESC_BYTE);
        del_hit   = esc_del && (byte_in == DEL_BYTE);
        need_esc  = fixed_hit || ctrl_hit || del_hit || (|ext_hit);
    end

endmodule

// File: rtl/ppp_tx_fcs_step.sv
module ppp_tx_fcs_step
    import ppp_tx_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data_in,
    input  logic        use32,
    output logic [31:0] crc_out
);

    always_comb begin
        logic [31:0] acc;
        acc = crc_in ^ {24'd0, data_in};
        if (!use32) begin
            acc = {16'd0, acc[15:0]};
        end
        for (int i = 0; i < 8; i++) begin
            if (acc[0]) begin
                acc = (acc >> 1) ^ (use32 ? POLY32 : POLY16);
            end else begin
                acc = acc >> 1;
            end
        end
        crc_out = acc;
    end

endmodule

// File: rtl/ppp_octet_tx.sv
module ppp_octet_tx
    import ppp_tx_pkg::*;
#(
    parameter int NUM_EXT = 4,
    localparam int EXT_W  = 8 * NUM_EXT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_fcs32,
    input  logic               cfg_share_flag,
    input  logic [31:0]        cfg_ctrl_map,
    input  logic               cfg_esc_del,
    input  logic [EXT_W-1:0]   cfg_ext_codes,
    input  logic [NUM_EXT-1:0] cfg_ext_en,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [7:0]         out_data
);

    localparam tx_regs_t REGS_RESET = '{
        state:       ST_IDLE,
        crc:         32'd0,
        fcs_idx:     2'd0,
        after_close: 1'b0,
        esc_pend:    1'b0,
        esc_byte:    8'd0,
        out_valid:   1'b0,
        out_data:    8'd0
    };

    tx_regs_t    q_q;
    tx_regs_t    q_d;

    logic        slot_free;
    logic        share_now;
    logic        take;
    logic [31:0] preset;
    logic [31:0] crc_base;
    logic [31:0] crc_next;
    logic [31:0] fcs_val;
    logic [7:0]  fcs_byte;
    logic [1:0]  fcs_last;
    logic [7:0]  cand;
    logic        cand_esc;

    assign slot_free = !q_q.out_valid || out_ready;
    assign share_now = cfg_share_flag && q_q.after_close;
    assign preset    = cfg_fcs32 ? PRESET32 : PRESET16;
    assign fcs_last  = cfg_fcs32 ? 2'd3 : 2'd1;
    assign fcs_val   = ~q_q.crc;
    assign fcs_byte  = fcs_val[{q_q.fcs_idx, 3'b000} +: 8];
    assign crc_base  = (q_q.state == ST_IDLE) ? preset : q_q.crc;
    assign cand      = (q_q.state == ST_FCS) ? fcs_byte : in_data;

    // Input acceptance: data bytes in a frame, a leading byte on a shared
    // flag, or any stray byte outside a frame (which is dropped).
    always_comb begin
        in_ready = 1'b0;
        if (slot_free && !q_q.esc_pend) begin
            case (q_q.state)
                ST_DATA: in_ready = 1'b1;
                ST_IDLE: in_ready = !in_sof || share_now;
                default: in_ready = 1'b0;
            endcase
        end
    end

    assign take = in_valid && in_ready;

    ppp_tx_fcs_step u_fcs (
        .crc_in  (crc_base),
        .data_in (in_data),
        .use32   (cfg_fcs32),
        .crc_out (crc_next)
    );

    ppp_tx_escape #(.NUM_EXT(NUM_EXT)) u_esc (
        .byte_in   (cand),
        .ctrl_map  (cfg_ctrl_map),
        .esc_del   (cfg_esc_del),
        .ext_codes (cfg_ext_codes),
        .ext_en    (cfg_ext_en),
        .need_esc  (cand_esc)
    );

    always_comb begin
        q_d = q_q;
        if (slot_free) begin
            q_d.out_valid = 1'b0;
            if (q_q.esc_pend) begin
                q_d.out_valid = 1'b1;
                q_d.out_data  = q_q.esc_byte;
                q_d.esc_pend  = 1'b0;
            end else begin
                case (q_q.state)
                    ST_IDLE: begin
                        if (in_valid && in_sof && share_now) begin
                            q_d.after_close = 1'b0;
                            q_d.crc         = crc_next;
                            q_d.out_valid   = 1'b1;
                            q_d.out_data    = cand_esc ? ESC_BYTE : cand;
                            q_d.esc_pend    = cand_esc;
                            q_d.esc_byte    = cand ^ ESC_XOR;
                            q_d.fcs_idx     = 2'd0;
                            q_d.state       = in_eof ? ST_FCS : ST_DATA;
                        end else if (in_valid && in_sof) begin
                            q_d.after_close = 1'b0;
                            q_d.crc         = preset;
                            q_d.out_valid   = 1'b1;
                            q_d.out_data    = FLAG_BYTE;
                            q_d.state       = ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (take) begin
                            q_d.crc       = crc_next;
                            q_d.out_valid = 1'b1;
                            q_d.out_data  = cand_esc ? ESC_BYTE : cand;
                            q_d.esc_pend  = cand_esc;
                            q_d.esc_byte  = cand ^ ESC_XOR;
                            if (in_eof) begin
                                q_d.fcs_idx = 2'd0;
                                q_d.state   = ST_FCS;
                            end
                        end
                    end
                    ST_FCS: begin
                        q_d.out_valid = 1'b1;
                        q_d.out_data  = cand_esc ? ESC_BYTE : cand;
                        q_d.esc_pend  = cand_esc;
                        q_d.esc_byte  = cand ^ ESC_XOR;
                        if (q_q.fcs_idx == fcs_last) begin
                            q_d.state = ST_CLOSE;
                        end else begin
                            q_d.fcs_idx = q_q.fcs_idx + 2'd1;
                        end
                    end
                    default: begin
                        q_d.out_valid   = 1'b1;
                        q_d.out_data    = FLAG_BYTE;
                        q_d.after_close = 1'b1;
                        q_d.state       = ST_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= REGS_RESET;
        end else begin
            q_q <= q_d;
        end
    end

    assign out_valid = q_q.out_valid;
    assign out_data  = q_q.out_data;

endmodule

// File: rtl/ppp_octet_tx_chk.sv
module ppp_octet_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_eof,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       frame_open
);

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R11

    AST_ESC_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data == 8'h7D) |-> !in_ready);  // R11

    AST_ESC_PAIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_data == 8'h7D) |=> out_valid);  // R6

    AST_FCS_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eof && frame_open) |=> !in_ready);  // R10

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);  // R1

endmodule

bind ppp_octet_tx ppp_octet_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_eof     (in_eof),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .frame_open (q_q.state != ST_IDLE)
);

// File: tb/ppp_octet_tx_test.sv
`timescale 1ns/1ps
module ppp_octet_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fcs32 = 1'b0;
    logic        cfg_share_flag = 1'b0;
    logic [31:0] cfg_ctrl_map = 32'd0;
    logic        cfg_esc_del = 1'b0;
    logic [31:0] cfg_ext_codes = 32'd0;
    logic [3:0]  cfg_ext_en = 4'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'd0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;

    always #2 clk = ~clk;

    ppp_octet_tx uut (.*);

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    bit          bp_mode = 1'b0;
    bit          mdl_closed = 1'b0;
    int          fcs_esc_seen = 0;
    logic [7:0]  exp_q[$];
    logic [7:0]  got_q[$];
    logic [7:0]  frm[$];

    // Output monitor: decide ready, record handshakes, check stalls.
    bit          was_stalled = 1'b0;
    logic [7:0]  stalled_data = 8'd0;
    always begin
        @(negedge clk);
        if (rst_n && was_stalled) begin
            checks++;
            if (!out_valid || out_data != stalled_data) begin
                errors++;
                $display("FAIL R11 stall hold: got valid=%0b data=%02h expected valid=1 data=%02h",
                         out_valid, out_data, stalled_data);
            end
        end
        out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
        was_stalled = out_valid && !out_ready;
        stalled_data = out_data;
        if (out_valid && out_ready) got_q.push_back(out_data);
        #1;
        if (rst_n && out_valid && out_data == 8'h7D) begin
            checks++;
            if (in_ready) begin
                errors++;
                $display("FAIL R11 input not held during escape pair: got in_ready=1 expected 0");
            end
        end
    end

    function automatic bit mdl_need(input logic [7:0] b);
        bit r;
        r = (b == 8'h7E) || (b == 8'h7D);
        if (b < 8'h20 && cfg_ctrl_map[b[4:0]]) r = 1'b1;
        if (b == 8'h7F && cfg_esc_del) r = 1'b1;
        for (int k = 0; k < 4; k++)
            if (cfg_ext_en[k] && cfg_ext_codes[8*k +: 8] == b) r = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] mdl_fcs(input logic [7:0] d[$], input bit w32);
        logic [31:0] c;
        logic        fb;
        c = w32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        foreach (d[i]) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ d[i][b];
                c = c >> 1;
                if (fb) c = c ^ (w32 ? 32'hEDB8_8320 : 32'h0000_8408);
            end
        end
        return w32 ? ~c : {16'd0, ~c[15:0]};
    endfunction

    task automatic mdl_push(input logic [7:0] b, input bit is_fcs);
        if (mdl_need(b)) begin
            exp_q.push_back(8'h7D);
            exp_q.push_back(b ^ 8'h20);
            if (is_fcs) fcs_esc_seen++;
        end else begin
            exp_q.push_back(b);
        end
    endtask

    task automatic mdl_frame(input logic [7:0] d[$]);
        logic [31:0] f;
        if (!(cfg_share_flag && mdl_closed)) exp_q.push_back(8'h7E);
        foreach (d[i]) mdl_push(d[i], 1'b0);
        f = mdl_fcs(d, cfg_fcs32);
        for (int i = 0; i < (cfg_fcs32 ? 4 : 2); i++) mdl_push(f[8*i +: 8], 1'b1);
        exp_q.push_back(8'h7E);
        mdl_closed = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit sof, input bit eof);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sof = sof; in_eof = eof;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d[$]);
        foreach (d[i]) send_byte(d[i], i == 0, i == d.size() - 1);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic compare(input string tag);
        int n;
        int bad;
        n = 0;
        while (got_q.size() < exp_q.size() && n < 3000) begin
            @(posedge clk);
            n++;
        end
        repeat (16) @(posedge clk);
        checks++;
        bad = -1;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s: byte %0d got %02h expected %02h", tag, bad, got_q[bad], exp_q[bad]);
        end else if (got_q.size() != exp_q.size()) begin
            errors++;
            $display("FAIL %s: stream length got %0d expected %0d", tag, got_q.size(), exp_q.size());
        end
        exp_q.delete();
        got_q.delete();
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int count_flags();
        int c;
        c = 0;
        foreach (got_q[i]) if (got_q[i] == 8'h7E) c++;
        return c;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R1: quiet during and right after reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 out_valid after reset", out_valid, 0);

        // R4: fixed 16-bit check value
        frm = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        exp_q = '{8'h7E, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39,
                  8'h6E, 8'h90, 8'h7E};
        send_frame(frm);
        compare("R4 fcs16 check value");

        // R5: fixed 32-bit check value
        cfg_fcs32 = 1'b1;
        exp_q = '{8'h7E, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39,
                  8'h26, 8'h39, 8'hF4, 8'hCB, 8'h7E};
        send_frame(frm);
        compare("R5 fcs32 check value");
        mdl_closed = 1'b1;

        // Sweep A: every byte value, 16-bit FCS, no back-pressure
        cfg_fcs32 = 1'b0;
        cfg_ctrl_map = 32'hA5C3_0F96;
        cfg_esc_del = 1'b1;
        cfg_ext_codes = {8'hFF, 8'h40, 8'hC3, 8'h80};
        cfg_ext_en = 4'b1011;
        for (int v = 0; v < 256; v++) begin
            frm = '{v[7:0]};
            mdl_frame(frm);
            send_frame(frm);
            compare("R6 R7 R8 R9 R10 sweep A");
        end

        // Sweep B: complementary map, 32-bit FCS, random output stalls
        cfg_fcs32 = 1'b1;
        cfg_ctrl_map = ~32'hA5C3_0F96;
        cfg_esc_del = 1'b0;
        cfg_ext_en = 4'b0100;
        bp_mode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            frm = '{v[7:0], 8'hFF - v[7:0]};
            mdl_frame(frm);
            send_frame(frm);
            compare("R6 R7 R8 R9 R10 R11 sweep B");
        end
        bp_mode = 1'b0;
        check_val("R10 frames with an escaped FCS byte", fcs_esc_seen > 0, 1);

        // R2: no sharing, three frames give six flags
        cfg_share_flag = 1'b0;
        cfg_ctrl_map = 32'd0;
        cfg_ext_en = 4'd0;
        for (int f = 0; f < 3; f++) begin
            frm = '{8'h41 + f[7:0], 8'h42, 8'h43};
            mdl_frame(frm);
            send_frame(frm);
        end
        repeat (40) @(posedge clk);
        check_val("R2 flag count without sharing", count_flags(), 6);
        compare("R2 three frames");

        // R3: sharing, three frames give three flags
        cfg_share_flag = 1'b1;
        cfg_fcs32 = 1'b0;
        for (int f = 0; f < 3; f++) begin
            frm = '{8'h51 + f[7:0], 8'h52};
            mdl_frame(frm);
            send_frame(frm);
        end
        repeat (40) @(posedge clk);
        check_val("R3 flag count with sharing", count_flags(), 3);
        compare("R3 shared flags");

        // R12: stray bytes outside a frame vanish and leave the CRC alone
        cfg_share_flag = 1'b0;
        send_byte(8'h7E, 1'b0, 1'b0);
        send_byte(8'h11, 1'b0, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        repeat (30) @(posedge clk);
        check_val("R12 no output for stray bytes", got_q.size(), 0);
        frm = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        exp_q = '{8'h7E, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39,
                  8'h6E, 8'h90, 8'h7E};
        send_frame(frm);
        compare("R12 frame after stray bytes");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule